// File: doc/BRIEF.md
# Little-Endian Variable-Length Instruction Extractor

This block sits between a byte-fill buffer and an instruction decoder. Bytes arrive one per cycle in memory order from a little-endian instruction stream and collect in a small internal window. Each instruction is 16, 32, 48 or 64 bits long. The major opcode lives in the upper half-word of each 32-bit group, so the length is worked out from bytes 2 and 3 of the window before bytes 0 and 1 are looked at. The block then reorders the bytes into a canonical word, left-justified in a 64-bit output, and presents it with a 2-bit length code.

A 16-bit instruction is lifted out of bytes 2 and 3 only. Bytes 0 and 1 stay where they are and become the start of the next window. Every other length removes bytes from the front of the window. After each removal, analysis restarts at the new bytes 2 and 3. A synchronous flush empties the window so that extraction can restart at a new aligned address after a redirect.

Top module: `le_insn_extract`

## Requirements
- R1: While reset is high, and in the cycle after it, out_valid is 0 and in_ready is 1.
- R2: The major opcode is bits 7:2 of window byte 3. Opcodes OP_C16_A/OP_C16_B (defaults 0, 1) give length code 0 (16-bit). OP_P48_A/OP_P48_B (defaults 2, 3) give code 2 (48-bit). OP_P64_A/OP_P64_B (defaults 4, 5) give code 3 (64-bit). Every other opcode, including 6 and 7, gives code 1 (32-bit).
- R3: A 16-bit instruction is output as {b3,b2} in bits 63:48, with the lower bits zero. Only bytes 2 and 3 are consumed. The old bytes 0 and 1 remain bytes 0 and 1 of the next window, followed by the old bytes 4 onward.
- R4: A 32-bit instruction is output as {b3,b2,b1,b0} in bits 63:32, with the lower bits zero, and consumes bytes 0 to 3.
- R5: A 48-bit instruction is output as {b2,b3,b0,b1,b4,b5} in bits 63:16, with the lower bits zero, and consumes bytes 0 to 5.
- R6: A 64-bit instruction is output as {b3,b2,b1,b0,b7,b6,b5,b4} (prefix word first) and consumes bytes 0 to 7.
- R7: out_valid is high only when the window holds at least 4 bytes, and at least 6 for a 48-bit or 8 for a 64-bit instruction. Until then the block stalls and keeps accepting bytes.
- R8: in_ready is high exactly when the window holds fewer than DEPTH bytes. A byte offered while in_ready is low is dropped. A byte accepted in the same cycle as an instruction is taken is appended right after the remaining bytes.
- R9: While out_valid is high and out_ready is low, out_valid, out_insn and out_len hold steady, even as more bytes arrive.
- R10: Flush empties the window at the next edge and discards any byte offered in the same cycle. The bytes that follow form a fresh window starting at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous window clear |
| in_valid | input | 1 | A stream byte is offered |
| in_data | input | 8 | Stream byte, in memory order |
| in_ready | output | 1 | The window has room for a byte |
| out_valid | output | 1 | A complete instruction is present |
| out_ready | input | 1 | The decoder takes the instruction |
| out_insn | output | 64 | Reassembled instruction, left-justified |
| out_len | output | 2 | Length code: 0=16, 1=32, 2=48, 3=64 bits |

## Verification
The outputs come from the registered window through logic alone, with no further register. The instruction, its length code and out_valid therefore appear in the cycle after the clock edge that accepts the byte completing it. A flush, a drop, or the reveal of the next window after a take shows one edge after the cycle in which it was requested. The bench changes inputs on the falling edge and samples one falling edge after the rising edge that acts on them. Stall cases are checked byte by byte, so each one confirms the exact byte that raises out_valid.

// File: rtl/le_insn_extract.sv
module le_insn_extract #(
  parameter int         DEPTH    = 16,
  parameter logic [5:0] OP_C16_A = 6'd0,
  parameter logic [5:0] OP_C16_B = 6'd1,
  parameter logic [5:0] OP_P48_A = 6'd2,
  parameter logic [5:0] OP_P48_B = 6'd3,
  parameter logic [5:0] OP_P64_A = 6'd4,
  parameter logic [5:0] OP_P64_B = 6'd5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_insn,
  output logic [1:0]  out_len
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    win [DEPTH];
  logic [7:0]    nxt [DEPTH];
  logic [CW-1:0] count;
  logic [CW-1:0] need;
  logic [CW-1:0] rem;
  logic [CW-1:0] wr;
  logic [5:0]    opc;
  logic          fire, push;

  assign opc = win[3][7:2];

  always_comb begin
    if (opc == OP_C16_A || opc == OP_C16_B)      out_len = 2'd0;
    else if (opc == OP_P48_A || opc == OP_P48_B) out_len = 2'd2;
    else if (opc == OP_P64_A || opc == OP_P64_B) out_len = 2'd3;
    else                                         out_len = 2'd1;
  end

  always_comb begin
    case (out_len)
      2'd0:    begin need = CW'(4); rem = CW'(2); end
      2'd1:    begin need = CW'(4); rem = CW'(4); end
      2'd2:    begin need = CW'(6); rem = CW'(6); end
      default: begin need = CW'(8); rem = CW'(8); end
    endcase
  end

  always_comb begin
    case (out_len)
      2'd0:    out_insn = {win[3], win[2], 48'd0};
      2'd1:    out_insn = {win[3], win[2], win[1], win[0], 32'd0};
      2'd2:    out_insn = {win[2], win[3], win[0], win[1], win[4], win[5], 16'd0};
      default: out_insn = {win[3], win[2], win[1], win[0], win[7], win[6], win[5], win[4]};
    endcase
  end

  assign out_valid = (count >= need);
  assign in_ready  = (count < CW'(DEPTH));
  assign fire      = out_valid & out_ready & ~flush;
  assign push      = in_valid & in_ready & ~flush;
  assign wr        = fire ? count - rem : count;

  always_comb begin
    int idx;
    for (int i = 0; i < DEPTH; i++) begin
      idx = i + int'(rem);
      if (!fire)                       nxt[i] = win[i];
      else if (out_len == 2'd0 && i < 2) nxt[i] = win[i];
      else if (idx < DEPTH)            nxt[i] = win[idx[AW-1:0]];
      else                             nxt[i] = 8'd0;
      if (push && i == int'(wr))       nxt[i] = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) win[i] <= 8'd0;
    end else begin
      count <= wr + CW'(push);
      for (int i = 0; i < DEPTH; i++) win[i] <= nxt[i];
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_insn) && $stable(out_len));

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0 && !out_valid && in_ready);

  assert_take_count_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !flush && !(in_valid && in_ready) |=> count == $past(count) - $past(rem));

  assert_keep_low_bytes_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !flush && out_len == 2'd0 |=> win[0] == $past(win[0]) && win[1] == $past(win[1]));
endmodule

// File: tb/test_le_insn_extract.sv
module test_le_insn_extract;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_insn;
  logic [1:0]  out_len;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  le_insn_extract i_le_insn_extract (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_len(out_len)
  );

  // {bytes b7..b0, length code, expected word}
  localparam logic [129:0] VEC [9] = '{
    {64'h7766_5544_025A_2211, 2'd0, 64'h025A_0000_0000_0000},
    {64'hF7E6_D5C4_07C3_B1A0, 2'd0, 64'h07C3_0000_0000_0000},
    {64'hFFEE_9A78_0B12_5634, 2'd2, 64'h120B_3456_789A_0000},
    {64'h0000_2301_0CAB_EFCD, 2'd2, 64'hAB0C_CDEF_0123_0000},
    {64'h5465_7687_1021_3243, 2'd3, 64'h1021_3243_5465_7687},
    {64'h6655_4433_1799_8877, 2'd3, 64'h1799_8877_6655_4433},
    {64'hDDCC_BBAA_1801_0203, 2'd1, 64'h1801_0203_0000_0000},
    {64'h0000_0000_FFEE_DDCC, 2'd1, 64'hFFEE_DDCC_0000_0000},
    {64'h1111_1111_2003_0201, 2'd1, 64'h2003_0201_0000_0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic fl();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic chk_word(input string tag, input logic [1:0] len, input logic [63:0] exp);
    chk(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
    chk(out_len == len, {tag, " length R2"}, 64'(out_len), 64'(len));
    chk(out_insn == exp, tag, out_insn, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    string t;
    @(negedge clk); @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", 64'(in_ready), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", {in_ready, out_valid}, 64'd2);

    for (int v = 0; v < 9; v++) begin
      fl();
      for (int k = 0; k < 8; k++) push(VEC[v][66 + 8*k +: 8]);
      case (VEC[v][65:64])
        2'd0: t = "R3 16-bit vector";
        2'd1: t = "R4 32-bit vector";
        2'd2: t = "R5 48-bit vector";
        default: t = "R6 64-bit vector";
      endcase
      chk_word(t, VEC[v][65:64], VEC[v][63:0]);
      pop();
    end

    // R3 retention of bytes 0 and 1 across 16-bit takes
    fl();
    push(8'h11); push(8'h22); push(8'h33); push(8'h04);
    push(8'h55); push(8'h01); push(8'h66); push(8'h77);
    chk_word("R3 first 16-bit", 2'd0, 64'h0433_0000_0000_0000);
    pop();
    chk_word("R3 second 16-bit", 2'd0, 64'h0155_0000_0000_0000);
    pop();
    chk_word("R3 kept bytes in 32-bit", 2'd1, 64'h7766_2211_0000_0000);
    pop();

    // R7 stall until enough bytes
    fl();
    push(8'h00); push(8'h00); push(8'h00);
    chk(out_valid == 1'b0, "R7 three bytes", 64'(out_valid), 64'd0);
    push(8'h00);
    chk_word("R7 16-bit at four bytes", 2'd0, 64'd0);
    fl();
    push(8'h00); push(8'h00); push(8'h00); push(8'h08);
    chk(out_valid == 1'b0, "R7 48-bit at four", 64'(out_valid), 64'd0);
    push(8'h00);
    chk(out_valid == 1'b0, "R7 48-bit at five", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R7 in_ready during stall", 64'(in_ready), 64'd1);
    push(8'h00);
    chk_word("R7 48-bit at six", 2'd2, 64'h0008_0000_0000_0000);
    fl();
    push(8'h00); push(8'h00); push(8'h00); push(8'h10);
    push(8'h00); push(8'h00); push(8'h00);
    chk(out_valid == 1'b0, "R7 64-bit at seven", 64'(out_valid), 64'd0);
    push(8'h00);
    chk_word("R7 64-bit at eight", 2'd3, 64'h1000_0000_0000_0000);

    // R8 full window, dropped byte, simultaneous take and fill
    fl();
    for (int w = 0; w < 4; w++) begin
      push(8'(w + 1)); push(8'(w + 1)); push(8'(w + 1)); push(8'h80);
    end
    chk(in_ready == 1'b0, "R8 full", 64'(in_ready), 64'd0);
    push(8'hF0);
    for (int w = 0; w < 4; w++) begin
      chk_word("R8 stored word", 2'd1, {8'h80, {3{8'(w + 1)}}, 32'd0});
      pop();
      chk(in_ready == 1'b1, "R8 room after take", 64'(in_ready), 64'd1);
    end
    push(8'hC0); push(8'hC1); push(8'hC2);
    chk(out_valid == 1'b0, "R8 byte while full dropped", 64'(out_valid), 64'd0);
    push(8'h83);
    chk_word("R8 word after drop", 2'd1, 64'h83C2_C1C0_0000_0000);
    out_ready = 1'b1; in_valid = 1'b1; in_data = 8'hD0;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b0;
    push(8'hD1); push(8'hD2); push(8'h84);
    chk_word("R8 take with fill", 2'd1, 64'h84D2_D1D0_0000_0000);
    pop();

    // R9 hold under back-pressure
    fl();
    push(8'h03); push(8'h02); push(8'h01); push(8'h88);
    chk_word("R9 before hold", 2'd1, 64'h8801_0203_0000_0000);
    push(8'hAA); push(8'hBB);
    chk_word("R9 held", 2'd1, 64'h8801_0203_0000_0000);

    // R10 flush
    fl();
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 after flush", {in_ready, out_valid}, 64'd2);
    flush = 1'b1; in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    push(8'h10); push(8'h20); push(8'h30);
    chk(out_valid == 1'b0, "R10 byte with flush dropped", 64'(out_valid), 64'd0);
    push(8'h8C);
    chk_word("R10 fresh window", 2'd1, 64'h8C30_2010_0000_0000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule